// File: doc/BRIEF.md
# Double-Buffered Isochronous OUT Receive Endpoint

This block is the receive side of one device endpoint that takes isochronous OUT packets. The upstream packet engine has already handled the PHY, the tokens and the CRC. It delivers a byte stream: a byte strobe with its data, then an end-of-packet strobe with a good/bad flag. Two packet buffers take turns. While software or a DMA engine drains the older packet through a one-byte data read port, the next packet can fill the other buffer. A packet that arrives while both buffers still hold unread packets is dropped whole, and the block reports it.

An 8-bit control/status register shows the endpoint state:

- a sticky packet-complete flag,
- a sticky overflow flag,
- a DMA-mode control bit,
- a not-empty flag for the buffer currently being read,
- a short-packet flag for that same buffer.

A receive interrupt line combines these flags with an external enable. In DMA mode the interrupt waits until fewer than a threshold number of bytes remain unread. Otherwise it fires as soon as a packet completes.

Top module: `iso_rx_endpoint`

## Requirements
- R1: After reset the register reads 8'h00, the interrupt is low and a data read returns 8'h00.
- R2: A packet that ends with the good flag high sets bit 1 (packet complete) in the cycle after its end strobe. Its bytes come out of the data port in arrival order, each one cycle after its read strobe.
- R3: Bit 1 stays set until a register write has a 1 in bit 1. A write with a 0 there leaves it set.
- R4: A second good packet is stored while the first is still unread. Packets are read out in the order they arrived. After the last byte of one packet is read, the other buffer becomes the read buffer.
- R5: A packet that starts while both buffers hold unread packets is discarded and the held data is left intact. Bit 2 (overflow) sets and raises the interrupt. A write of 1 to bit 2 clears it.
- R6: With bit 3 clear, the interrupt equals enable AND (bit 1 OR bit 2).
- R7: With bit 3 set, a completed packet raises the interrupt only while fewer than DMA_THRESH (default 32) bytes remain unread in the read buffer.
- R8: Bit 6 (not empty) is 1 exactly while the read buffer has unread bytes. It falls after the last byte is read.
- R9: Bit 7 (short) is 1 when the read buffer holds a packet of fewer than MAX_PKT (default 256) bytes. It is 0 for a full-size packet or when no packet is held.
- R10: A zero-length packet shows bit 7 = 1 with bit 6 = 0. Its buffer is released when the next packet begins, and bit 7 then follows the new packet.
- R11: A packet that ends with the good flag low changes no status bit and takes no buffer. The next good packet reads back alone.
- R12: A data read while the read buffer has no unread bytes returns 8'h00 and does not move the read position.
- R13: Bits 0, 4 and 5 read as 0 and ignore writes. Bit 3 is a plain read/write bit that resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Incoming byte strobe |
| in_byte | input | 8 | Incoming data byte |
| in_eop | input | 1 | End-of-packet strobe |
| in_good | input | 1 | Packet good flag, sampled with in_eop |
| rd_en | input | 1 | Data register read strobe |
| rd_data | output | 8 | Data register, valid one cycle after rd_en |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read value |
| irq_en | input | 1 | Receive interrupt enable |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A byte read or a register write issued in one cycle is visible after the next rising edge. The complete flag rises one edge after the end strobe. The overflow flag rises one edge after the first strobe of a dropped packet. The not-empty and short flags change one edge after the read that empties a buffer. The interrupt is combinational from those flags and the enable, so it moves in the same cycle as they do. The bench drives every input on the falling edge and samples on the following falling edge, which lies after exactly one register stage.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;
   // Register bit positions, as software decodes them
   localparam int CPL_POS   = 1;
   localparam int OVF_POS   = 2;
   localparam int DMA_POS   = 3;
   localparam int NE_POS    = 6;
   localparam int SHORT_POS = 7;

   typedef struct packed {
      logic cpl;
      logic ovf;
      logic dma;
      logic ne;
      logic short_pkt;
   } rx_stat_t;

   function automatic logic [7:0] pack_csr(input rx_stat_t s);
      logic [7:0] v;
      v            = 8'h00;
      v[CPL_POS]   = s.cpl;
      v[OVF_POS]   = s.ovf;
      v[DMA_POS]   = s.dma;
      v[NE_POS]    = s.ne;
      v[SHORT_POS] = s.short_pkt;
      return v;
   endfunction
endpackage

// File: rtl/iso_rx_buf.sv
module iso_rx_buf #(
   parameter int MAX_PKT = 256,
   parameter int AW      = 8,
   parameter int CW      = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_byte,
   input  logic          commit,
   input  logic [CW-1:0] commit_cnt,
   input  logic          release_buf,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_byte,
   output logic          held,
   output logic [CW-1:0] cnt,
   output logic          is_short
);
   localparam logic [CW-1:0] MAX_C = CW'(MAX_PKT);

   logic [7:0] mem [MAX_PKT];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_byte;
   end

   assign rd_byte = mem[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held     <= 1'b0;
         cnt      <= '0;
         is_short <= 1'b0;
      end else if (commit) begin
         held     <= 1'b1;
         cnt      <= commit_cnt;
         is_short <= (commit_cnt < MAX_C);
      end else if (release_buf) begin
         held     <= 1'b0;
      end
   end

   // a packet is committed only into a buffer that is free or being freed
   assert_commit_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (!held || release_buf));

   // only a buffer holding a packet can be handed back
   assert_release_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      release_buf |-> held);
endmodule

// File: rtl/iso_rx_csr.sv
module iso_rx_csr
   import iso_rx_pkg::*;
#(
   parameter int CW         = 9,
   parameter int DMA_THRESH = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          csr_wr,
   input  logic [7:0]    csr_wdata,
   input  logic          set_cpl,
   input  logic          set_ovf,
   input  logic          ne,
   input  logic          short_pkt,
   input  logic [CW-1:0] remain,
   input  logic          irq_en,
   output logic [7:0]    csr_rdata,
   output logic          dma_en,
   output logic          rx_irq
);
   localparam logic [CW-1:0] TH_C = CW'(DMA_THRESH);

   logic     cpl_q, ovf_q, dma_q, near_empty;
   rx_stat_t stat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpl_q <= 1'b0;
         ovf_q <= 1'b0;
         dma_q <= 1'b0;
      end else begin
         // a new event wins over a clear in the same cycle
         cpl_q <= set_cpl | (cpl_q & ~(csr_wr & csr_wdata[CPL_POS]));
         ovf_q <= set_ovf | (ovf_q & ~(csr_wr & csr_wdata[OVF_POS]));
         if (csr_wr) dma_q <= csr_wdata[DMA_POS];
      end
   end

   assign near_empty = (remain < TH_C);
   assign rx_irq     = irq_en & (ovf_q | (cpl_q & (~dma_q | near_empty)));
   assign dma_en     = dma_q;

   always_comb begin
      stat.cpl       = cpl_q;
      stat.ovf       = ovf_q;
      stat.dma       = dma_q;
      stat.ne        = ne;
      stat.short_pkt = short_pkt;
      csr_rdata      = pack_csr(stat);
   end

   assert_cpl_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_cpl |=> csr_rdata[CPL_POS]);

   assert_cpl_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rdata[CPL_POS] && !(csr_wr && csr_wdata[CPL_POS])) |=> csr_rdata[CPL_POS]);

   assert_ovf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      set_ovf |=> (csr_rdata[OVF_POS] && (rx_irq || !irq_en)));
endmodule

// File: rtl/iso_rx_endpoint.sv
module iso_rx_endpoint
   import iso_rx_pkg::*;
#(
   parameter int MAX_PKT    = 256,
   parameter int DMA_THRESH = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_vld,
   input  logic [7:0] in_byte,
   input  logic       in_eop,
   input  logic       in_good,
   input  logic       rd_en,
   output logic [7:0] rd_data,
   input  logic       csr_wr,
   input  logic [7:0] csr_wdata,
   output logic [7:0] csr_rdata,
   input  logic       irq_en,
   output logic       rx_irq
);
   localparam int AW = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1;
   localparam int CW = $clog2(MAX_PKT + 1);
   localparam logic [CW-1:0] MAX_C = CW'(MAX_PKT);

   if (MAX_PKT < 1 || MAX_PKT > 4096) begin : g_chk_size
      $error("MAX_PKT out of range");
   end
   if (DMA_THRESH < 1 || DMA_THRESH > MAX_PKT) begin : g_chk_thresh
      $error("DMA_THRESH must lie in 1..MAX_PKT");
   end

   // fill side state
   logic          rx_busy, rx_drop, wr_idx;
   logic [CW-1:0] wr_cnt;
   // drain side state
   logic          act;
   logic [CW-1:0] rd_ptr;
   logic [7:0]    rd_q;

   // per-buffer views
   logic [1:0]    held, b_short, commit_v, release_v;
   logic [7:0]    b_rd  [2];
   logic [CW-1:0] b_cnt [2];

   logic          start, zlp_act, zlp_rel, room, accept, wr_fire;
   logic          pkt_end, commit_any, ovf_hit, rne, rd_take, rd_last, dma_unused;
   logic [CW-1:0] cur_cnt, end_cnt, act_cnt, remain;

   always_comb begin
      act_cnt    = b_cnt[act];
      start      = !rx_busy && (in_vld || in_eop);
      zlp_act    = held[act] && (act_cnt == '0);
      zlp_rel    = start && zlp_act;
      room       = !held[wr_idx] || (zlp_rel && (act == wr_idx));
      accept     = start ? room : (rx_busy && !rx_drop);
      cur_cnt    = start ? '0 : wr_cnt;
      wr_fire    = in_vld && accept && (cur_cnt < MAX_C);
      end_cnt    = cur_cnt + CW'(wr_fire);
      pkt_end    = in_eop && (rx_busy || start);
      commit_any = pkt_end && accept && in_good;
      ovf_hit    = start && !room;
      rne        = held[act] && (rd_ptr < act_cnt);
      rd_take    = rd_en && rne;
      rd_last    = rd_take && ((rd_ptr + CW'(1)) == act_cnt);
      remain     = held[act] ? (act_cnt - rd_ptr) : '0;
   end

   for (genvar g = 0; g < 2; g++) begin : g_buf
      assign commit_v[g]  = commit_any && (wr_idx == 1'(g));
      assign release_v[g] = (rd_last || zlp_rel) && (act == 1'(g));

      iso_rx_buf #(.MAX_PKT(MAX_PKT), .AW(AW), .CW(CW)) u_buf (
         .clk         (clk),
         .rst_n       (rst_n),
         .wr_en       (wr_fire && (wr_idx == 1'(g))),
         .wr_addr     (cur_cnt[AW-1:0]),
         .wr_byte     (in_byte),
         .commit      (commit_v[g]),
         .commit_cnt  (end_cnt),
         .release_buf (release_v[g]),
         .rd_addr     (rd_ptr[AW-1:0]),
         .rd_byte     (b_rd[g]),
         .held        (held[g]),
         .cnt         (b_cnt[g]),
         .is_short    (b_short[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_busy <= 1'b0;
         rx_drop <= 1'b0;
         wr_cnt  <= '0;
         wr_idx  <= 1'b0;
      end else begin
         if (pkt_end)    rx_busy <= 1'b0;
         else if (start) rx_busy <= 1'b1;
         if (start)      rx_drop <= !room;
         if (pkt_end)              wr_cnt <= '0;
         else if (start || wr_fire) wr_cnt <= end_cnt;
         if (commit_any) wr_idx <= ~wr_idx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act    <= 1'b0;
         rd_ptr <= '0;
         rd_q   <= 8'h00;
      end else begin
         if (rd_last || zlp_rel) act <= ~act;
         if (rd_last)      rd_ptr <= '0;
         else if (rd_take) rd_ptr <= rd_ptr + CW'(1);
         rd_q <= rd_take ? b_rd[act] : 8'h00;
      end
   end

   assign rd_data = rd_q;

   iso_rx_csr #(.CW(CW), .DMA_THRESH(DMA_THRESH)) u_csr (
      .clk       (clk),
      .rst_n     (rst_n),
      .csr_wr    (csr_wr),
      .csr_wdata (csr_wdata),
      .set_cpl   (commit_any),
      .set_ovf   (ovf_hit),
      .ne        (rne),
      .short_pkt (held[act] & b_short[act]),
      .remain    (remain),
      .irq_en    (irq_en),
      .csr_rdata (csr_rdata),
      .dma_en    (dma_unused),
      .rx_irq    (rx_irq)
   );

   // a read with nothing to read yields zero on the next cycle
   assert_empty_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !csr_rdata[NE_POS]) |=> (rd_data == 8'h00));

   // with no packet held, read and write sides point at the same buffer
   assert_idle_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (held == 2'b00) |-> (act == wr_idx));
endmodule

// File: tb/sim_iso_rx_endpoint.sv
module sim_iso_rx_endpoint;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_vld = 1'b0, in_eop = 1'b0, in_good = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       rd_en = 1'b0, csr_wr = 1'b0, irq_en = 1'b0;
   logic [7:0] csr_wdata = 8'h00;
   logic [7:0] rd_data, csr_rdata;
   logic       rx_irq;
   int         total = 0, bad = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   iso_rx_endpoint u0 (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte),
      .in_eop(in_eop), .in_good(in_good), .rd_en(rd_en), .rd_data(rd_data),
      .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .irq_en(irq_en), .rx_irq(rx_irq)
   );

   task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
      total++;
      if (act_v !== exp_v) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
      end
   endtask

   task automatic send_pkt(input int len, input logic [7:0] base, input logic good);
      for (int i = 0; i < len; i++) begin
         in_vld  = 1'b1;
         in_byte = 8'(base + i);
         @(negedge clk);
      end
      in_vld  = 1'b0;
      in_eop  = 1'b1;
      in_good = good;
      @(negedge clk);
      in_eop  = 1'b0;
      in_good = 1'b0;
   endtask

   task automatic read_expect(input string tag, input logic [7:0] exp_b);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk(tag, rd_data, exp_b);
   endtask

   task automatic read_run(input string tag, input int len, input logic [7:0] base);
      for (int i = 0; i < len; i++) read_expect(tag, 8'(base + i));
   endtask

   task automatic csr_write(input logic [7:0] v);
      csr_wr    = 1'b1;
      csr_wdata = v;
      @(negedge clk);
      csr_wr    = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 csr", csr_rdata, 8'h00);
      chk("R1 irq", rx_irq, 1'b0);
      read_expect("R1 rd", 8'h00);
   endtask

   task automatic t_reserved;
      csr_write(8'hFF);
      chk("R13 reserved/dma set", csr_rdata, 8'h08);
      csr_write(8'h00);
      chk("R13 dma clear", csr_rdata, 8'h00);
   endtask

   task automatic t_basic;
      irq_en = 1'b1;
      send_pkt(10, 8'h30, 1'b1);
      chk("R2 R9 csr after packet", csr_rdata, 8'hC2);
      chk("R6 irq at end", rx_irq, 1'b1);
      irq_en = 1'b0;
      #1 chk("R6 irq gated", rx_irq, 1'b0);
      irq_en = 1'b1;
      read_run("R2 data", 9, 8'h30);
      chk("R8 ne before last", csr_rdata[6], 1'b1);
      read_expect("R2 last byte", 8'h39);
      chk("R8 R9 after drain", csr_rdata, 8'h02);
      csr_write(8'h00);
      chk("R3 write 0 keeps", csr_rdata, 8'h02);
      csr_write(8'h02);
      chk("R3 w1c", csr_rdata, 8'h00);
      chk("R6 irq cleared", rx_irq, 1'b0);
   endtask

   task automatic t_empty_read;
      read_expect("R12 empty", 8'h00);
      chk("R12 csr unchanged", csr_rdata, 8'h00);
      send_pkt(3, 8'h50, 1'b1);
      read_run("R12 pointer kept", 3, 8'h50);
      csr_write(8'h02);
      chk("R12 done", csr_rdata, 8'h00);
   endtask

   task automatic t_pingpong;
      send_pkt(256, 8'h00, 1'b1);
      send_pkt(5, 8'hA0, 1'b1);
      chk("R9 full size not short", csr_rdata, 8'h42);
      read_run("R4 first packet", 256, 8'h00);
      chk("R4 R9 second active", csr_rdata, 8'hC2);
      read_run("R4 second packet", 5, 8'hA0);
      chk("R8 both drained", csr_rdata, 8'h02);
      csr_write(8'h02);
   endtask

   task automatic t_overflow;
      send_pkt(4, 8'h10, 1'b1);
      send_pkt(4, 8'h20, 1'b1);
      send_pkt(4, 8'h90, 1'b1);
      chk("R5 ovf set", csr_rdata, 8'hC6);
      chk("R5 irq", rx_irq, 1'b1);
      csr_write(8'h02);
      chk("R5 ovf stays", csr_rdata, 8'hC4);
      chk("R5 irq from ovf", rx_irq, 1'b1);
      csr_write(8'h04);
      chk("R5 ovf w1c", csr_rdata, 8'hC0);
      chk("R6 irq low", rx_irq, 1'b0);
      read_run("R5 held data A", 4, 8'h10);
      read_run("R5 held data B", 4, 8'h20);
      chk("R5 nothing else", csr_rdata, 8'h00);
   endtask

   task automatic t_dma;
      csr_write(8'h08);
      send_pkt(40, 8'h40, 1'b1);
      chk("R7 no irq at 40 left", rx_irq, 1'b0);
      read_run("R7 data", 8, 8'h40);
      chk("R7 no irq at 32 left", rx_irq, 1'b0);
      read_expect("R7 data", 8'h48);
      chk("R7 irq at 31 left", rx_irq, 1'b1);
      read_run("R7 rest", 31, 8'h49);
      csr_write(8'h0A);
      chk("R13 dma kept", csr_rdata, 8'h08);
      csr_write(8'h00);
   endtask

   task automatic t_zlp;
      send_pkt(0, 8'h00, 1'b1);
      chk("R10 zlp status", csr_rdata, 8'h82);
      read_expect("R10 zlp read", 8'h00);
      csr_write(8'h02);
      chk("R10 short stays", csr_rdata, 8'h80);
      send_pkt(3, 8'h60, 1'b1);
      chk("R10 next packet", csr_rdata, 8'hC2);
      read_run("R10 data", 3, 8'h60);
      csr_write(8'h02);
      chk("R10 clear", csr_rdata, 8'h00);
   endtask

   task automatic t_bad;
      send_pkt(6, 8'h70, 1'b0);
      chk("R11 status untouched", csr_rdata, 8'h00);
      chk("R11 irq", rx_irq, 1'b0);
      send_pkt(2, 8'h77, 1'b1);
      chk("R11 good after bad", csr_rdata, 8'hC2);
      read_run("R11 data", 2, 8'h77);
      chk("R11 only good", csr_rdata, 8'h02);
      csr_write(8'h02);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_reserved;
      t_basic;
      t_empty_read;
      t_pingpong;
      t_overflow;
      t_dma;
      t_zlp;
      t_bad;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule